// File: doc/BRIEF.md
# Command-Processor Arithmetic/Logic Execute Stage

This block decodes and executes the arithmetic and logic instructions of a small command-processor microcontroller. Each cycle it may accept one 32-bit instruction word, with the values already read from the register file for the two source fields. One clock later it presents the destination register index, the 32-bit result, a write enable, the packed repeat flag and the two-bit extra-move field. Register file storage, branches, memory and control-register access belong to neighbouring blocks. For those instructions the block drops the write enable and produces nothing else.

Three encodings are handled. The immediate form combines a source register with a zero-extended 16-bit constant. The move-immediate form shifts the constant left by a 5-bit amount. The two-register form takes its operation from the low bits of the word. A stored carry/borrow bit lets a 64-bit add or subtract run as a low-word instruction followed by a high-word instruction.

Top module: `cp_alu`

## Requirements
- R1: Header bits [31:26] below 0x30 give opcode = header>>1 and repeat flag = header bit 0. Headers of 0x30 and above are full 6-bit opcodes: repeat is 0 and the write enable is 0.
- R2: Immediate form: the constant is [15:0] (zero-extended), the destination is [20:16] and the source at [25:21] arrives on `src1_val`. Add (0x01), sub (0x03), and (0x05), or (0x06) and xor (0x07) give the 32-bit result of source op constant.
- R3: Not (0x08) yields the bitwise inverse of the second operand and ignores `src1_val`.
- R4: Shift left (0x09), logical right (0x0a), arithmetic right (0x0b) and rotate left (0x0c) shift the source by the low 5 bits of the second operand.
- R5: Multiply (0x0d) yields the zero-extended 16-bit product of the low 8 bits of both operands.
- R6: Min (0x0e) and max (0x0f) compare both operands as unsigned 32-bit values.
- R7: Compare (0x10) yields 0 when equal, 1 when the source is greater and 2 when the source is smaller, unsigned.
- R8: Move-immediate (0x11) yields the 16-bit constant shifted left by the amount in [25:21].
- R9: Header opcode 0x13 selects the two-register form. The operation is [4:0], the destination is [15:11], source 1 comes from [25:21] on `src1_val` and source 2 from [20:16] on `src2_val`. The extra-move field [10:9] is passed to `res_xmov`. In this form, op 0x11 copies source 2, and reserved bits [8:5] that are not zero drop the write enable.
- R10: Op 0x14 in the two-register form yields the index of the highest set bit of source 2, and 0 when source 2 is 0. As a header opcode, 0x14 does not write.
- R11: Add and sub set the stored carry (carry-out / borrow). Add-high (0x02) adds it in and sub-high (0x04) subtracts it, and both update it. Other instructions leave it unchanged. Reset clears it.
- R12: Outputs register one cycle after `instr_valid`. `res_valid` follows `instr_valid` by one cycle. Nop (0x00), unlisted opcodes and out-of-scope headers give `res_wen` = 0.
- R13: During reset, `res_valid`, `res_wen`, `res_rep` and `res_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| src1_val | input | 32 | Register value for field [25:21] |
| src2_val | input | 32 | Register value for field [20:16] (two-register form) |
| res_valid | output | 1 | A result slot is present |
| res_wen | output | 1 | Write the result to the register file |
| res_dst | output | 5 | Destination register index |
| res_data | output | 32 | Result value |
| res_rep | output | 1 | Repeat flag from the header |
| res_xmov | output | 2 | Extra-move count from the two-register form |

## Verification
The assertions check on every cycle that the result slot trails the input by exactly one cycle, and that no write occurs without a slot. They also check that long headers never raise the repeat flag, that move-immediate and not results match the instruction fields, and that the carry holds across every instruction outside the add/sub family. The bench scenarios are needed to show the arithmetic itself. These cover wrap and borrow values, chaining of the high-word operations across unrelated instructions, signed against unsigned shifts, the rotate wrap, the unsigned ordering in min, max and compare, and the most-significant-bit index at zero and one.

// File: rtl/cp_alu_pkg.sv
// Shared encodings for the command-processor ALU stage.
// Assumes the 32-bit instruction layout described in the brief.
package cp_alu_pkg;

    localparam int INSTR_W  = 32;
    localparam int REG_AW   = 5;
    localparam int IMM_W    = 16;
    localparam int HDR_W    = 6;
    localparam int XMOV_W   = 2;
    localparam logic [HDR_W-1:0] HDR_LONG_BASE = 6'h30;

    typedef enum logic [4:0] {
        OP_NOP   = 5'h00,
        OP_ADD   = 5'h01,
        OP_ADDHI = 5'h02,
        OP_SUB   = 5'h03,
        OP_SUBHI = 5'h04,
        OP_AND   = 5'h05,
        OP_OR    = 5'h06,
        OP_XOR   = 5'h07,
        OP_NOT   = 5'h08,
        OP_SHL   = 5'h09,
        OP_USHR  = 5'h0a,
        OP_ISHR  = 5'h0b,
        OP_ROTL  = 5'h0c,
        OP_MUL8  = 5'h0d,
        OP_MIN   = 5'h0e,
        OP_MAX   = 5'h0f,
        OP_CMP   = 5'h10,
        OP_MOV   = 5'h11,
        OP_TWOREG = 5'h13,
        OP_MSB   = 5'h14
    } alu_op_e;

    typedef struct packed {
        alu_op_e              op;
        logic                 legal;
        logic                 two_reg;
        logic                 rep;
        logic [REG_AW-1:0]    dst;
        logic [REG_AW-1:0]    shamt;
        logic [IMM_W-1:0]     imm;
        logic [XMOV_W-1:0]    xmov;
    } dec_t;

endpackage

// File: rtl/cp_alu_decode.sv
// Instruction decoder: splits the header into opcode and repeat flag,
// picks the immediate or two-register field layout and flags legality.
// Assumes headers at or above 0x30 belong to other execution units.
module cp_alu_decode
    import cp_alu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);

    localparam int HDR_LSB = INSTR_W - HDR_W;

    logic [HDR_W-1:0] hdr;
    logic             long_hdr;
    logic [4:0]       hdr_op;
    logic [4:0]       sel_op;
    logic             pad_zero;

    assign hdr      = instr[INSTR_W-1:HDR_LSB];
    assign long_hdr = (hdr >= HDR_LONG_BASE);
    assign hdr_op   = hdr[HDR_W-1:1];
    assign pad_zero = (instr[8:5] == 4'h0);

    // Field selection between the immediate and two-register layouts.
    always_comb begin
        dec.two_reg = !long_hdr && (hdr_op == OP_TWOREG);
        dec.rep     = long_hdr ? 1'b0 : hdr[0];
        sel_op      = dec.two_reg ? instr[4:0] : hdr_op;
        dec.op      = alu_op_e'(sel_op);
        dec.dst     = dec.two_reg ? instr[15:11] : instr[20:16];
        dec.shamt   = dec.two_reg ? '0 : instr[25:21];
        dec.imm     = instr[IMM_W-1:0];
        dec.xmov    = dec.two_reg ? instr[10:9] : '0;
    end

    // Legality: listed ALU ops, MSB only in the two-register form.
    always_comb begin
        dec.legal = 1'b0;
        if (!long_hdr) begin
            if (sel_op >= OP_ADD && sel_op <= OP_MOV)
                dec.legal = 1'b1;
            else if (dec.two_reg && sel_op == OP_MSB)
                dec.legal = 1'b1;
            if (dec.two_reg && !pad_zero)
                dec.legal = 1'b0;
        end
    end

endmodule

// File: rtl/cp_alu_msb.sv
// Highest-set-bit index finder; yields 0 for an all-zero input.
// Assumes W is a power of two.
module cp_alu_msb #(
    parameter int W = 32,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    output logic [IW-1:0] idx
);

    // Ascending scan so the last set bit seen wins.
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (val[i])
                idx = IW'(i);
        end
    end

endmodule

// File: rtl/cp_alu_exec.sv
// Datapath: evaluates one ALU operation on two 32-bit operands and
// reports the new carry/borrow for the add/sub family.
// Assumes operand B is already the immediate or the second register.
module cp_alu_exec
    import cp_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MUL_W  = 8,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  alu_op_e            op,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    input  logic [REG_AW-1:0]  shamt,
    input  logic               carry_i,
    output logic [DATA_W-1:0]  result,
    output logic               carry_o,
    output logic               carry_we
);

    logic [DATA_W:0]     sum_w;
    logic [DATA_W:0]     diff_w;
    logic                cin;
    logic [SH_W-1:0]     sh;
    logic [2*DATA_W-1:0] rot_w;
    logic [2*MUL_W-1:0]  prod;
    logic [SH_W-1:0]     msb_idx;

    assign sh = b[SH_W-1:0];

    // Shared adder and subtractor with optional chained carry.
    always_comb begin
        cin    = (op == OP_ADDHI || op == OP_SUBHI) ? carry_i : 1'b0;
        sum_w  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        diff_w = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
        rot_w  = {a, a} << sh;
        prod   = a[MUL_W-1:0] * b[MUL_W-1:0];
    end

    cp_alu_msb #(.W(DATA_W)) u_msb (
        .val (b),
        .idx (msb_idx)
    );

    // Result multiplexer over all operations.
    always_comb begin
        result   = '0;
        carry_o  = carry_i;
        carry_we = 1'b0;
        case (op)
            OP_ADD, OP_ADDHI: begin
                result   = sum_w[DATA_W-1:0];
                carry_o  = sum_w[DATA_W];
                carry_we = 1'b1;
            end
            OP_SUB, OP_SUBHI: begin
                result   = diff_w[DATA_W-1:0];
                carry_o  = diff_w[DATA_W];
                carry_we = 1'b1;
            end
            OP_AND:  result = a & b;
            OP_OR:   result = a | b;
            OP_XOR:  result = a ^ b;
            OP_NOT:  result = ~b;
            OP_SHL:  result = a << sh;
            OP_USHR: result = a >> sh;
            OP_ISHR: result = DATA_W'($signed(a) >>> sh);
            OP_ROTL: result = rot_w[2*DATA_W-1:DATA_W];
            OP_MUL8: result = DATA_W'(prod);
            OP_MIN:  result = (a < b) ? a : b;
            OP_MAX:  result = (a > b) ? a : b;
            OP_CMP:  result = (a == b) ? DATA_W'(0) : ((a > b) ? DATA_W'(1) : DATA_W'(2));
            OP_MOV:  result = b << shamt;
            OP_MSB:  result = DATA_W'(msb_idx);
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/cp_alu.sv
// Execute stage top: decode, operand select, datapath, carry storage
// and the output register. One instruction per cycle, one-cycle latency.
// Assumes register values are presented in the same cycle as the word.
module cp_alu
    import cp_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MUL_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                instr_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [DATA_W-1:0]   src1_val,
    input  logic [DATA_W-1:0]   src2_val,
    output logic                res_valid,
    output logic                res_wen,
    output logic [REG_AW-1:0]   res_dst,
    output logic [DATA_W-1:0]   res_data,
    output logic                res_rep,
    output logic [XMOV_W-1:0]   res_xmov
);

    dec_t              dec;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] result;
    logic              carry_q;
    logic              carry_nx;
    logic              carry_we;

    cp_alu_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    // Second operand: register in two-register form, else the constant.
    assign opnd_b = dec.two_reg ? src2_val : DATA_W'(dec.imm);

    cp_alu_exec #(.DATA_W(DATA_W), .MUL_W(MUL_W)) u_exec (
        .op       (dec.op),
        .a        (src1_val),
        .b        (opnd_b),
        .shamt    (dec.shamt),
        .carry_i  (carry_q),
        .result   (result),
        .carry_o  (carry_nx),
        .carry_we (carry_we)
    );

    // Carry/borrow storage for high-word chaining.
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_q <= 1'b0;
        else if (instr_valid && dec.legal && carry_we)
            carry_q <= carry_nx;
    end

    // Output register for the write-back port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_wen   <= 1'b0;
            res_dst   <= '0;
            res_data  <= '0;
            res_rep   <= 1'b0;
            res_xmov  <= '0;
        end else begin
            res_valid <= instr_valid;
            res_wen   <= instr_valid && dec.legal;
            if (instr_valid) begin
                res_dst  <= dec.dst;
                res_data <= dec.legal ? result : '0;
                res_rep  <= dec.rep;
                res_xmov <= dec.xmov;
            end
        end
    end

endmodule

// File: rtl/cp_alu_chk.sv
// Assertion checker for cp_alu, attached with bind.
module cp_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic [31:0] instr,
    input logic        res_valid,
    input logic        res_wen,
    input logic        res_rep,
    input logic [31:0] res_data,
    input logic        carry_q
);

    logic [4:0] hop;
    logic       short_hdr;
    logic       addsub_fam;

    assign hop       = instr[31:27];
    assign short_hdr = (instr[31:26] < 6'h30);
    assign addsub_fam = short_hdr &&
        (((hop >= 5'h01) && (hop <= 5'h04)) ||
         ((hop == 5'h13) && (instr[4:0] >= 5'h01) && (instr[4:0] <= 5'h04)));

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (res_valid == $past(instr_valid))); // R12

    AST_WEN_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        res_wen |-> res_valid); // R12

    AST_LONG_NO_REP: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !short_hdr) |=> (!res_rep && !res_wen)); // R1

    AST_NOT_IGNORES_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && short_hdr && hop == 5'h08)
        |=> (res_data == ~{16'h0, $past(instr[15:0])})); // R3

    AST_MOVI_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && hop == 5'h11)
        |=> (res_data == ({16'h0, $past(instr[15:0])} << $past(instr[25:21])))); // R8

    AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr_valid && addsub_fam) |=> $stable(carry_q)); // R11

endmodule

bind cp_alu cp_alu_chk u_cp_alu_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .res_valid   (res_valid),
    .res_wen     (res_wen),
    .res_rep     (res_rep),
    .res_data    (res_data),
    .carry_q     (carry_q)
);

// File: tb/tb_cp_alu.sv
`timescale 1ns/1ps
module tb_cp_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src1_val = '0;
    logic [31:0] src2_val = '0;
    logic        res_valid;
    logic        res_wen;
    logic [4:0]  res_dst;
    logic [31:0] res_data;
    logic        res_rep;
    logic [1:0]  res_xmov;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic        wen;
        logic [4:0]  dst;
        logic [31:0] data;
        logic        rep;
        logic [1:0]  xmov;
        logic        full;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    cp_alu dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .src1_val(src1_val), .src2_val(src2_val), .res_valid(res_valid),
        .res_wen(res_wen), .res_dst(res_dst), .res_data(res_data),
        .res_rep(res_rep), .res_xmov(res_xmov)
    );

    function automatic logic [31:0] mk_imm(logic [4:0] op, logic rep, logic [4:0] s,
                                           logic [4:0] d, logic [15:0] imm);
        return {op, rep, s, d, imm};
    endfunction

    function automatic logic [31:0] mk_rr(logic [4:0] op, logic rep, logic [4:0] s1,
                                          logic [4:0] s2, logic [4:0] d, logic [1:0] xm);
        return {5'h13, rep, s1, s2, d, xm, 4'h0, op};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: presents one instruction and queues its expected result.
    task automatic issue(logic [31:0] w, logic [31:0] a, logic [31:0] b, logic wen,
                         logic [4:0] d, logic [31:0] data, logic rep, logic full, string tag);
        exp_t e;
        @(negedge clk);
        instr = w; src1_val = a; src2_val = b; instr_valid = 1'b1;
        e.wen = wen; e.dst = d; e.data = data; e.rep = rep;
        e.xmov = full ? w[10:9] & {2{w[31:27] == 5'h13}} : 2'b00;
        e.full = full; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            instr_valid = 1'b0;
        end
    endtask

    // Monitor: pops the scoreboard whenever a result slot appears.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                check("R12 unexpected slot", 64'(res_valid), 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " wen"}, 64'(res_wen), 64'(e.wen));
                check({e.tag, " rep"}, 64'(res_rep), 64'(e.rep));
                if (e.full) begin
                    check({e.tag, " dst"}, 64'(res_dst), 64'(e.dst));
                    check({e.tag, " data"}, 64'(res_data), 64'(e.data));
                    check({e.tag, " xmov"}, 64'(res_xmov), 64'(e.xmov));
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13 valid", 64'(res_valid), 64'd0);
        check("R13 wen", 64'(res_wen), 64'd0);
        check("R13 rep", 64'(res_rep), 64'd0);
        check("R13 data", 64'(res_data), 64'd0);
        rst_n = 1'b1;

        // R11: carry clear after reset, then add/add-high chain
        issue(mk_imm(5'h02,0,1,2,16'd6), 32'd5, 0, 1, 2, 32'd11, 0, 1, "R11 addhi after reset");
        issue(mk_imm(5'h01,0,1,3,16'h0020), 32'hFFFF_FFF0, 0, 1, 3, 32'h10, 0, 1, "R2 add wrap");
        issue(mk_imm(5'h05,0,1,4,16'h00FF), 32'hF0F0_F0F0, 0, 1, 4, 32'hF0, 0, 1, "R2 and");
        issue(mk_imm(5'h02,0,1,5,16'd2), 32'd1, 0, 1, 5, 32'd4, 0, 1, "R11 addhi carry kept over and");
        issue(mk_imm(5'h02,0,1,5,16'd2), 32'd1, 0, 1, 5, 32'd3, 0, 1, "R11 addhi carry consumed");
        issue(mk_imm(5'h03,0,1,6,16'd6), 32'd5, 0, 1, 6, 32'hFFFF_FFFF, 0, 1, "R2 sub borrow");
        issue(mk_imm(5'h04,0,1,7,16'd3), 32'd10, 0, 1, 7, 32'd6, 0, 1, "R11 subhi borrow");
        issue(mk_imm(5'h04,0,1,7,16'd3), 32'd10, 0, 1, 7, 32'd7, 0, 1, "R11 subhi no borrow");
        issue(mk_imm(5'h06,0,1,8,16'h5678), 32'h1234_0000, 0, 1, 8, 32'h1234_5678, 0, 1, "R2 or");
        issue(mk_imm(5'h07,0,1,9,16'h0F0F), 32'h0000_FFFF, 0, 1, 9, 32'h0000_F0F0, 0, 1, "R2 xor");
        // R3
        issue(mk_imm(5'h08,0,1,10,16'h00FF), 32'h1234_5678, 0, 1, 10, 32'hFFFF_FF00, 0, 1, "R3 not");
        // R4
        issue(mk_imm(5'h09,0,1,11,16'd31), 32'd1, 0, 1, 11, 32'h8000_0000, 0, 1, "R4 shl 31");
        issue(mk_imm(5'h09,0,1,11,16'h0024), 32'd1, 0, 1, 11, 32'h10, 0, 1, "R4 shl low bits");
        issue(mk_imm(5'h0a,0,1,12,16'd4), 32'h8000_0000, 0, 1, 12, 32'h0800_0000, 0, 1, "R4 ushr");
        issue(mk_imm(5'h0b,0,1,12,16'd4), 32'h8000_0000, 0, 1, 12, 32'hF800_0000, 0, 1, "R4 ishr");
        issue(mk_imm(5'h0c,0,1,13,16'd1), 32'h8000_0001, 0, 1, 13, 32'h3, 0, 1, "R4 rotl");
        // R5
        issue(mk_imm(5'h0d,0,1,14,16'h03FF), 32'h1FF, 0, 1, 14, 32'hFE01, 0, 1, "R5 mul8");
        // R6
        issue(mk_imm(5'h0e,0,1,15,16'd5), 32'hFFFF_FFFF, 0, 1, 15, 32'd5, 0, 1, "R6 min");
        issue(mk_imm(5'h0f,0,1,15,16'd5), 32'hFFFF_FFFF, 0, 1, 15, 32'hFFFF_FFFF, 0, 1, "R6 max");
        // R7
        issue(mk_imm(5'h10,0,1,16,16'd7), 32'd7, 0, 1, 16, 32'd0, 0, 1, "R7 cmp eq");
        issue(mk_imm(5'h10,0,1,16,16'd7), 32'd8, 0, 1, 16, 32'd1, 0, 1, "R7 cmp gt");
        issue(mk_imm(5'h10,0,1,16,16'd7), 32'd6, 0, 1, 16, 32'd2, 0, 1, "R7 cmp lt");
        issue(mk_imm(5'h10,0,1,16,16'hFFFF), 32'h1_0000, 0, 1, 16, 32'd1, 0, 1, "R7 cmp unsigned");
        // R8
        issue(mk_imm(5'h11,0,5'd16,17,16'hABCD), 32'hDEAD, 0, 1, 17, 32'hABCD_0000, 0, 1, "R8 movi 16");
        issue(mk_imm(5'h11,0,5'd0,17,16'hABCD), 32'hDEAD, 0, 1, 17, 32'h0000_ABCD, 0, 1, "R8 movi 0");
        // R1
        issue(mk_imm(5'h01,1,1,18,16'd1), 32'd1, 0, 1, 18, 32'd2, 1, 1, "R1 repeat flag");
        issue(32'hC7FF_FFFF, 0, 0, 0, 0, 0, 0, 0, "R1 long header");
        // R12
        issue(mk_imm(5'h00,0,1,1,16'd1), 32'd1, 0, 0, 0, 0, 0, 0, "R12 nop");
        issue(mk_imm(5'h12,0,1,1,16'd1), 32'd1, 0, 0, 0, 0, 0, 0, "R12 unlisted op");
        // R9
        issue(mk_rr(5'h01,0,3,4,19,2'd2), 32'hFFFF_FFFF, 32'd1, 1, 19, 32'd0, 0, 1, "R9 rr add");
        issue(mk_rr(5'h02,0,3,4,19,2'd1), 32'd0, 32'd0, 1, 19, 32'd1, 0, 1, "R9 R11 rr addhi");
        issue(mk_rr(5'h03,1,3,4,20,2'd3), 32'd9, 32'd4, 1, 20, 32'd5, 1, 1, "R9 rr sub");
        issue(mk_rr(5'h08,0,3,4,21,2'd0), 32'h55, 32'h0F0F_0F0F, 1, 21, 32'hF0F0_F0F0, 0, 1, "R9 R3 rr not");
        issue(mk_rr(5'h11,0,3,4,22,2'd0), 32'h1, 32'hCAFE_F00D, 1, 22, 32'hCAFE_F00D, 0, 1, "R9 rr mov");
        issue(mk_rr(5'h01,0,3,4,22,2'd0) | 32'h0000_0040, 32'd1, 32'd1, 0, 0, 0, 0, 0, "R9 pad nonzero");
        issue(mk_rr(5'h1f,0,3,4,22,2'd0), 32'd1, 32'd1, 0, 0, 0, 0, 0, "R9 rr unlisted op");
        // R10
        issue(mk_rr(5'h14,0,3,4,23,2'd0), 32'hFFFF, 32'd0, 1, 23, 32'd0, 0, 1, "R10 msb zero");
        issue(mk_rr(5'h14,0,3,4,23,2'd0), 32'hFFFF, 32'd1, 1, 23, 32'd0, 0, 1, "R10 msb one");
        issue(mk_rr(5'h14,0,3,4,23,2'd0), 32'd0, 32'h0001_0000, 1, 23, 32'd16, 0, 1, "R10 msb 16");
        issue(mk_rr(5'h14,0,3,4,23,2'd0), 32'd0, 32'h8000_0001, 1, 23, 32'd31, 0, 1, "R10 msb 31");
        issue(mk_imm(5'h14,0,1,23,16'd8), 32'd8, 0, 0, 0, 0, 0, 0, "R10 msb immediate form");

        idle(4);
        check("R12 scoreboard drained", 64'(sb.size()), 64'd0);
        finish_run();
    end

endmodule